// File: doc/BRIEF.md
# Keyed Watchdog Timer with Register Interface

This block is a down-counting watchdog that a processor controls through a small register bus. Software writes a period code and a separate code for the first period, sets the enable bit, and must then write a fixed key to the restart register before the counter reaches zero. The load value for period code `i` is `2^(EXP_BASE+i)` clock cycles. `EXP_BASE` defaults to 16, so the codes cover 2^16 to 2^31 cycles with a 32-bit counter.

If the counter runs out, the block responds in one of two ways. In reset mode it drives a system reset pulse straight away. In interrupt mode the first expiry raises a sticky interrupt and reloads the counter, and a second expiry without a valid restart drives the reset pulse. The enable bit is sticky: once set, only a hardware reset clears it. After the reset pulse the block freezes until its own reset input is asserted.

The bus is a plain register port. A transfer is presented with `bus_valid` high for one cycle and is always accepted, so there is no back-pressure. Read data appears on `bus_rdata` in the cycle after the read and holds until the next read.

Top module: `wdt_top`

## Requirements
- R1: Register select is `bus_addr[3:2]`: 0 = control, 1 = range, 2 = count, 3 = restart. Read data is registered and appears one cycle after the read. Control reads back as {mode in bit 1, enable in bit 0}. Range reads back its 8 bits. The restart register and all unused bits read as zero.
- R2: Writing 1 to control bit 0 sets the enable. Writing 0 later does not clear it, and counting continues. Only `rst_n` clears it.
- R3: While disabled, the count register reads `2^(EXP_BASE+init)`, where init is range bits [7:4]. Restart writes while disabled are ignored. After reset both codes are 0.
- R4: While enabled and not fired, the count drops by exactly one per clock.
- R5: The first countdown after enable starts from the initial-code load value. Expiry is registered one cycle after the count reaches zero, so with load L the response output rises L+1 edges after the edge that loaded the counter. Each later countdown uses range bits [3:0].
- R6: A write to the restart register whose data bits [7:0] equal 0x76 reloads the counter with `2^(EXP_BASE+period)`, visible from the next cycle. Any other data value leaves the count unchanged.
- R7: With control bit 1 = 0, expiry raises `sys_rst_o` and `irq_o` stays low.
- R8: With control bit 1 = 1, the first expiry sets `irq_o` and reloads the counter. A second expiry with no valid restart in between raises `sys_rst_o`.
- R9: A valid restart clears `irq_o` on the next cycle.
- R10: `sys_rst_o` stays high for exactly `RST_PULSE` cycles and then stays low. From then on the count holds its value (the period load) and restarts are ignored until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Transfer strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Sticky timeout interrupt |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bench measures the exact number of edges from a reload to the response. An off-by-one in the zero detect or in the expiry register would move the interrupt or reset by a cycle. It writes 0 to the enable and wrong key bytes, because a design that lets either through would stop counting or restart it. Separate runs cover the initial period against the running period, and the second expiry in interrupt mode against a restart between expiries. A design that mixes up the two codes, or forgets to clear the interrupt flag, would fire at the wrong time. After the pulse it checks the pulse width and that the count stays frozen, including against a late key write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_RANGE   = 2'd1,
    SEL_COUNT   = 2'd2,
    SEL_RESTART = 2'd3
  } wdt_sel_e;

  typedef enum logic [1:0] {
    RSP_ARMED  = 2'd0,
    RSP_PULSE  = 2'd1,
    RSP_HALTED = 2'd2
  } wdt_rsp_e;

  localparam logic [7:0] RESTART_KEY = 8'h76;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned NUM_CODES = 1 << CODE_W;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_value,
  output logic              en,
  output logic              mode,
  output logic [CODE_W-1:0] period_code,
  output logic [CODE_W-1:0] init_code,
  output logic              kick,
  output logic [DATA_W-1:0] bus_rdata
);
  wdt_sel_e sel;
  logic     hit, wr, rd;
  logic     unused_bits;
  logic [DATA_W-1:0] rd_next;

  assign sel = wdt_sel_e'(bus_addr[3:2]);
  assign hit = bus_valid && ((bus_addr >> 4) == '0);
  assign wr  = hit && bus_write;
  assign rd  = hit && !bus_write;
  assign unused_bits = ^{bus_wdata[DATA_W-1:8], bus_addr[1:0]};

  // Restart only counts once the timer is running and the key matches.
  assign kick = wr && (sel == SEL_RESTART) && (bus_wdata[7:0] == RESTART_KEY) && en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en          <= 1'b0;
      mode        <= 1'b0;
      period_code <= '0;
      init_code   <= '0;
    end else if (wr) begin
      if (sel == SEL_CTRL) begin
        en   <= en | bus_wdata[0];
        mode <= bus_wdata[1];
      end
      if (sel == SEL_RANGE) begin
        period_code <= bus_wdata[CODE_W-1:0];
        init_code   <= bus_wdata[2*CODE_W-1:CODE_W];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    case (sel)
      SEL_CTRL:  rd_next[1:0] = {mode, en};
      SEL_RANGE: rd_next[2*CODE_W-1:0] = {init_code, period_code};
      SEL_COUNT: rd_next[CNT_W-1:0] = cnt_value;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_next;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned EXP_BASE = 16,
  parameter int unsigned CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              halt,
  input  logic              kick,
  input  logic [CODE_W-1:0] period_code,
  input  logic [CODE_W-1:0] init_code,
  output logic [CNT_W-1:0]  cnt,
  output logic              expire
);
  logic [CNT_W-1:0] load_tbl [NUM_CODES];

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_load
    assign load_tbl[g] = CNT_W'(1) << (EXP_BASE + g);
  end

  assign expire = en && !halt && !kick && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= load_tbl[0];
    else if (!en)             cnt <= load_tbl[init_code];
    else if (halt)            cnt <= cnt;
    else if (kick || expire)  cnt <= load_tbl[period_code];
    else                      cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/wdt_response.sv
module wdt_response
  import wdt_pkg::*;
#(
  parameter int unsigned RST_PULSE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode,
  input  logic expire,
  input  logic kick,
  output logic irq,
  output logic sys_rst,
  output logic halt
);
  localparam int unsigned PW = $clog2(RST_PULSE + 1);

  wdt_rsp_e        state;
  logic [PW-1:0]   left;

  assign halt = (state != RSP_ARMED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RSP_ARMED;
      left    <= '0;
      irq     <= 1'b0;
      sys_rst <= 1'b0;
    end else begin
      case (state)
        RSP_ARMED: begin
          if (kick) begin
            irq <= 1'b0;
          end else if (expire) begin
            if (mode && !irq) begin
              irq <= 1'b1;
            end else begin
              state   <= RSP_PULSE;
              left    <= PW'(RST_PULSE - 1);
              sys_rst <= 1'b1;
            end
          end
        end
        RSP_PULSE: begin
          if (left == '0) begin
            sys_rst <= 1'b0;
            state   <= RSP_HALTED;
          end else begin
            left <= left - PW'(1);
          end
        end
        default: state <= RSP_HALTED;
      endcase
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned EXP_BASE  = 16,
  parameter int unsigned RST_PULSE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);
  localparam int unsigned CNT_W = EXP_BASE + NUM_CODES;

  logic              en_w, mode_w, kick_w, halt_w, expire_w;
  logic [CODE_W-1:0] period_w, init_w;
  logic [CNT_W-1:0]  cnt_w;

  wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_value(cnt_w),
    .en(en_w), .mode(mode_w), .period_code(period_w), .init_code(init_w),
    .kick(kick_w), .bus_rdata(bus_rdata)
  );

  wdt_counter #(.EXP_BASE(EXP_BASE), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_w), .halt(halt_w), .kick(kick_w),
    .period_code(period_w), .init_code(init_w), .cnt(cnt_w), .expire(expire_w)
  );

  wdt_response #(.RST_PULSE(RST_PULSE)) u_rsp (
    .clk(clk), .rst_n(rst_n), .mode(mode_w), .expire(expire_w), .kick(kick_w),
    .irq(irq_o), .sys_rst(sys_rst_o), .halt(halt_w)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned EXP_BASE  = 16,
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned RST_PULSE = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             halt,
  input logic             kick,
  input logic             expire,
  input logic [3:0]       period_code,
  input logic [3:0]       init_code,
  input logic [CNT_W-1:0] cnt,
  input logic             sys_rst
);
  localparam int unsigned RW = $clog2(RST_PULSE + 2);

  logic [RW-1:0] run_len;

  function automatic logic [CNT_W-1:0] span(input logic [3:0] c);
    return CNT_W'(1) << (EXP_BASE + int'(c));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= '0;
    else if (sys_rst) run_len <= run_len + RW'(1);
    else              run_len <= '0;
  end

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) en |=> en); // R2
  AST_IDLE_TRACKS_INIT: assert property (@(posedge clk) disable iff (!rst_n) !en |=> cnt == span($past(init_code))); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n) (en && !halt && !kick && cnt != '0) |=> cnt == $past(cnt) - CNT_W'(1)); // R4
  AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n) (kick && !halt) |=> cnt == span($past(period_code))); // R6
  AST_RST_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(sys_rst) |-> $past(expire)); // R7
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) sys_rst |-> run_len < RW'(RST_PULSE)); // R10
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) halt |=> $stable(cnt)); // R10
endmodule

bind wdt_top wdt_checker #(.EXP_BASE(EXP_BASE), .CNT_W(CNT_W), .RST_PULSE(RST_PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_w), .halt(halt_w), .kick(kick_w), .expire(expire_w),
  .period_code(period_w), .init_code(init_w), .cnt(cnt_w), .sys_rst(sys_rst_o)
);

// File: tb/wdt_top_test.sv
`timescale 1ns/1ps
module wdt_top_test;
  localparam int unsigned EXP_BASE  = 4;
  localparam int unsigned RST_PULSE = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, sys_rst_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdt_top #(.EXP_BASE(EXP_BASE), .RST_PULSE(RST_PULSE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  function automatic int unsigned ld(int code);
    return 32'd1 << (EXP_BASE + code);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge; each bus access takes one edge.
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  // Counts edges until the chosen output is high (0 = irq, 1 = reset).
  task automatic wait_out(int which, int limit, inout int c);
    while (((which == 0) ? irq_o : sys_rst_o) !== 1'b1 && c < limit) begin
      @(negedge clk);
      c++;
    end
  endtask

  task automatic t_reset_and_regs();
    logic [31:0] v;
    do_reset();
    check("R1 reset irq", {31'b0, irq_o}, 0);
    check("R1 reset sys_rst", {31'b0, sys_rst_o}, 0);
    rd(4'h0, v); check("R1 ctrl reset", v, 0);
    rd(4'h4, v); check("R1 range reset", v, 0);
    rd(4'h8, v); check("R3 idle count reset", v, ld(0));
    wr(4'h4, 32'hFFFF_FF5A);
    rd(4'h4, v); check("R1 range masked", v, 32'h5A);
    wr(4'h0, 32'hFFFF_FFFE);
    rd(4'h0, v); check("R1 ctrl bits", v, 32'h2);
    rd(4'hC, v); check("R1 restart reads zero", v, 0);
    rd(4'h8, v); check("R3 idle count init code", v, ld(5));
  endtask

  task automatic t_idle_enable_keys();
    logic [31:0] v, a;
    do_reset();
    wr(4'h4, 32'h32);
    @(negedge clk);
    wr(4'hC, 32'h76);
    rd(4'h8, v); check("R3 restart ignored while disabled", v, ld(3));
    wr(4'h0, 32'h1);
    rd(4'h8, v); check("R5 first load from init code", v, ld(3));
    rd(4'h8, a);
    repeat (10) @(negedge clk);
    rd(4'h8, v); check("R4 count down one per cycle", v, a - 11);
    wr(4'h0, 32'h0);
    rd(4'h0, v); check("R2 enable stays set", v, 32'h1);
    rd(4'h8, a);
    wr(4'hC, 32'h75);
    rd(4'h8, v); check("R6 wrong key ignored", v, a - 2);
    wr(4'hC, 32'h67);
    rd(4'h8, v); check("R6 swapped key ignored", v, a - 4);
    wr(4'hC, 32'h76);
    rd(4'h8, v); check("R6 key reloads period", v, ld(2));
  endtask

  task automatic t_reset_mode();
    logic [31:0] v;
    int c = 0;
    int w = 0;
    wr(4'hC, 32'h76);
    wait_out(1, 200, c);
    check("R7 reset after period plus one", c, ld(2) + 1);
    check("R7 no irq in reset mode", {31'b0, irq_o}, 0);
    while (sys_rst_o === 1'b1 && w < 50) begin
      @(negedge clk);
      w++;
    end
    check("R10 pulse width", w, RST_PULSE);
    repeat (5) @(negedge clk);
    check("R10 pulse stays low", {31'b0, sys_rst_o}, 0);
    rd(4'h8, v); check("R10 count frozen", v, ld(2));
    wr(4'hC, 32'h76);
    repeat (3) @(negedge clk);
    rd(4'h8, v); check("R10 restart ignored after fire", v, ld(2));
  endtask

  task automatic t_irq_mode();
    int c = 0;
    do_reset();
    wr(4'h0, 32'h3);
    wr(4'hC, 32'h76);
    wait_out(0, 200, c);
    check("R8 first expiry irq", c, ld(0) + 1);
    check("R8 no reset on first expiry", {31'b0, sys_rst_o}, 0);
    wait_out(1, 200, c);
    check("R8 second expiry resets", c, 2 * (ld(0) + 1));
    check("R8 irq held", {31'b0, irq_o}, 1);
  endtask

  task automatic t_irq_clear();
    int c = 0;
    do_reset();
    wr(4'h0, 32'h3);
    wr(4'hC, 32'h76);
    wait_out(0, 200, c);
    wr(4'hC, 32'h76);
    check("R9 restart clears irq", {31'b0, irq_o}, 0);
    c = 0;
    wait_out(0, 200, c);
    check("R9 irq again after full period", c, ld(0) + 1);
    check("R9 no reset after cleared irq", {31'b0, sys_rst_o}, 0);
  endtask

  task automatic t_init_period();
    int c = 0;
    do_reset();
    wr(4'h4, 32'h10);
    wr(4'h0, 32'h3);
    wait_out(0, 200, c);
    check("R5 first expiry uses init code", c, ld(1) + 1);
    wait_out(1, 200, c);
    check("R5 later period uses period code", c, ld(1) + ld(0) + 2);
  endtask

  initial begin
    @(negedge clk);
    t_reset_and_regs();
    t_idle_enable_keys();
    t_reset_mode();
    t_irq_mode();
    t_irq_clear();
    t_init_period();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule